// File: doc/BRIEF.md
# Platform Environment Control Interface Register Stub

This block stands in for the host-side register file of a platform environment control controller. It has the register layout and interrupt behaviour of a real controller but no wire engine behind it. Software writes the enable and data registers, then sets the launch bit in the command word. The stub completes the command in the same clock cycle. It loads a fixed success completion code into the first transmit and first receive buffer words, and it raises a command-done event.

The event does not accumulate. It overwrites the status word with the enable mask ANDed with the event bit. The interrupt line is a registered level that stays high while status is nonzero. Status bits are cleared by writing ones to them. A launch is refused while any status bit is still set.

The bus is a simple single-cycle register port: byte address, write data, write strobe, read strobe and combinational read data. Address bits [1:0] are ignored. Addresses at or above 0x40 fall outside the 16-word window.

Top module: `peci_reg_stub`

## Requirements
- R1: After reset, every in-window word reads 0 and `irq_o` is low.
- R2: A write to any in-window word other than 0x08 and 0x1C stores all 32 bits, and reading that word returns them. Address bits [1:0] select nothing.
- R3: The command word at 0x08 always reads 0. A write to it with bit 0 clear changes no register and does not change `irq_o`.
- R4: A write of bit 0 = 1 to 0x08 while the status word (0x1C) is 0 loads 0x00000040 into word 0x20 and word 0x30. The same write replaces status with the enable word (0x18) ANDed with 0x1, where bit 0 means command done.
- R5: A launch write while status is nonzero is ignored: words 0x20, 0x30 and 0x1C keep their values.
- R6: `irq_o` is updated one clock edge after the write that changes status. It is high exactly when status is nonzero, so a launch with enable bit 0 clear loads the data words but leaves `irq_o` low.
- R7: A write to 0x1C clears the status bits written as 1 and leaves the other bits. `irq_o` falls once status becomes 0.
- R8: A read at an address of 0x40 or above returns 0. A write there changes no register.
- R9: `rdata_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one transfer per cycle |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Level interrupt, high while status is nonzero |

## Verification
The bench builds the stub with its defaults: a 12-bit address and 16 words. With these values, random addresses up to 0x7F reach every in-window word, and half of them land out of window. Random traffic hits the command and status words often enough to cover launches refused while status is pending, clears that leave status set, and launches made with the enable bit both set and clear.

// File: rtl/peci_reg_stub.sv
module peci_reg_stub #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 16,
  parameter logic [31:0] CC_OK = 32'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int IDX_W   = $clog2(NUM_WORDS);
  localparam int SPAN    = NUM_WORDS * 4;
  localparam int CMD_IDX = 2;
  localparam int IEN_IDX = 6;
  localparam int STS_IDX = 7;
  localparam int TXD_IDX = 8;
  localparam int RXD_IDX = 12;

  logic [31:0] mem [NUM_WORDS];
  logic [31:0] sts, ien, sts_nxt;
  logic [IDX_W-1:0] idx;
  logic in_win, wr_cmd, wr_sts, fire_ok;

  assign idx     = addr_i[IDX_W+1:2];
  assign in_win  = addr_i < ADDR_W'(SPAN);
  assign sts     = mem[STS_IDX];
  assign ien     = mem[IEN_IDX];
  assign wr_cmd  = wr_en_i && in_win && idx == IDX_W'(CMD_IDX);
  assign wr_sts  = wr_en_i && in_win && idx == IDX_W'(STS_IDX);
  assign fire_ok = wr_cmd && wdata_i[0] && sts == '0;

  always_comb begin
    sts_nxt = sts;
    if (fire_ok)     sts_nxt = ien & 32'h1;
    else if (wr_sts) sts_nxt = sts & ~wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_en_i && in_win && !wr_cmd && !wr_sts) mem[idx] <= wdata_i;
      if (fire_ok) begin
        mem[TXD_IDX] <= CC_OK;
        mem[RXD_IDX] <= CC_OK;
      end
      mem[STS_IDX] <= sts_nxt;
      irq_o        <= |sts_nxt;
    end
  end

  assign rdata_o = (rd_en_i && in_win && idx != IDX_W'(CMD_IDX)) ? mem[idx] : '0;
endmodule

// File: rtl/peci_reg_stub_chk.sv
module peci_reg_stub_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [31:0]       sts,
  input logic [31:0]       ien
);
  logic a_cmd, a_sts, a_oor;
  assign a_oor = addr_i >= ADDR_W'(64);
  assign a_cmd = !a_oor && addr_i[5:2] == 4'd2;
  assign a_sts = !a_oor && addr_i[5:2] == 4'd7;

  AST_FIRE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && a_cmd && wdata_i[0] && sts == 0 |=> sts == ($past(ien) & 32'h1)); // R4
  AST_FIRE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && a_cmd && sts != 0 |=> $stable(sts)); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sts != 0)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && a_sts |=> (sts & $past(wdata_i)) == 0); // R7
  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && a_cmd |-> rdata_o == 0); // R3
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && a_oor |-> rdata_o == 0); // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 0); // R9
endmodule

bind peci_reg_stub peci_reg_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .sts(sts), .ien(ien));

// File: tb/tb_peci_reg_stub.sv
module tb_peci_reg_stub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  logic [31:0] m [16];

  always #10 clk = ~clk;

  peci_reg_stub dut (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a >= 12'h40 || a[5:2] == 4'd2) return 32'h0;
    return m[a[5:2]];
  endfunction

  function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h40) return;
    case (a[5:2])
      4'd2: if (d[0] && m[7] == 0) begin m[8] = 32'h40; m[12] = 32'h40; m[7] = m[6] & 32'h1; end
      4'd7: m[7] = m[7] & ~d;
      default: m[a[5:2]] = d;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'h40) return "R8";
    case (a[5:2])
      4'd2: return "R3";
      4'd7: return "R7";
      4'd8, 4'd12: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
    check("R6 irq", {31'b0, irq}, {31'b0, m[7] != 0});
  endtask

  task automatic bus_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #5 check(tag, rdata, exp_rd(a));
    rd_en = 1'b0;
    #1 check("R9", rdata, 32'h0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) bus_rd(12'(i * 4), "R1");
    check("R1 irq", {31'b0, irq}, 32'h0);

    bus_wr(12'h05, 32'hDEADBEEF); bus_rd(12'h07, "R2");
    bus_wr(12'h3C, 32'h12345678); bus_rd(12'h3C, "R2");
    bus_wr(12'h08, 32'hFFFFFFFE); bus_rd(12'h20, "R3"); bus_rd(12'h08, "R3");
    bus_wr(12'h18, 32'h0);        bus_wr(12'h08, 32'h1);
    bus_rd(12'h20, "R4"); bus_rd(12'h30, "R4"); bus_rd(12'h1C, "R6");
    bus_wr(12'h18, 32'h1); bus_wr(12'h20, 32'h0); bus_wr(12'h08, 32'h1);
    bus_rd(12'h20, "R4"); bus_rd(12'h1C, "R4");
    check("R6 irq high", {31'b0, irq}, 32'h1);
    bus_wr(12'h20, 32'h77); bus_wr(12'h08, 32'h1);
    bus_rd(12'h20, "R5"); bus_rd(12'h1C, "R5");
    bus_wr(12'h1C, 32'h2); bus_rd(12'h1C, "R7");
    bus_wr(12'h1C, 32'h1); bus_rd(12'h1C, "R7");
    check("R7 irq low", {31'b0, irq}, 32'h0);
    bus_wr(12'h40, 32'hAAAA5555); bus_wr(12'hFFC, 32'h1);
    bus_rd(12'h40, "R8"); bus_rd(12'h00, "R8");

    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = 12'($urandom_range(0, 127));
      case ($urandom_range(0, 3))
        0: a = 12'h08 | 12'($urandom_range(0, 3));
        1: a = 12'h1C;
        default: ;
      endcase
      d = $urandom;
      if ($urandom_range(0, 1) == 1) bus_wr(a, d);
      else bus_rd(a, tag_of(a));
    end
    for (int i = 0; i < 32; i++) bus_rd(12'(i * 4), tag_of(12'(i * 4)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule